// File: doc/BRIEF.md
# Dual-CPU Two-Stage Interrupt Mask Controller

This block takes a set of level-sensitive device interrupt lines and drives one interrupt output per CPU. A source reaches a CPU only after it clears two stacked gates. The first is a shared enable bit per source. The second is a mask bit per source that is held separately for each CPU. A controller-wide run bit in the control register gates every output as well. Software can also make a source pending by writing its number to a trigger register. It then withdraws that pending state with an acknowledge write.

All state changes go through a simple single-cycle register bus. Each access carries the number of the issuing CPU. The shared enable is changed through a pair of set and clear command registers. Each of these takes a source number in the write data. The per-CPU mask is changed through a second set/clear pair that sits in an alias window. The same alias address reaches the mask bank of whichever CPU issues the access. A per-source routing register in the main space rewrites that source's unmask bits for every CPU in one write, and it reads them back. This register is the way affinity is set.

Top module: `irq_dual_mask_ctrl`

## Requirements
- R1: `cpu_irq[c]` is high one clock after all four of these conditions hold, and low one clock after any of them stops holding. The conditions are: the source is pending (device line high or software pending), its shared enable is set, it is unmasked for CPU c, and control bit 0 (run) at address 0x000 is 1.
- R2: After a synchronous active-low reset, these all read 0: every shared enable, every software-pending bit, the run bit, `cpu_irq` and `bus_rdata`. Every source is also masked for every CPU.
- R3: A write to 0x008 sets, and a write to 0x00C clears, the shared enable of the source numbered in `bus_wdata[9:0]`. No other source's bit changes.
- R4: A write to 0x804 unmasks, and a write to 0x800 masks, the numbered source in the mask bank of the CPU given by `bus_cpu`.
- R5: A write to 0x800 or 0x804 leaves the mask bank of every other CPU unchanged.
- R6: The routing register of source n sits at 0x100 + 4n. A write sets source n's unmask bit for CPU c to `bus_wdata[c]`, for every CPU at once. A read returns those bits in `bus_rdata[1:0]`, with the other bits 0.
- R7: A write of source n to 0x004 makes source n pending. A write of n to 0x010 withdraws that software-pending state. A device line that is high keeps its source pending whatever the software-pending state is.
- R8: Reads of 0x004, 0x008, 0x00C, 0x010, 0x800 and 0x804 return 0. A read of 0x000 returns the run bit in bit 0.
- R9: Some command writes are ignored. These are a command write whose source number is 32 or more, and a write to a routing address beyond source 31. Such a write changes no state, and a read of such a routing address returns 0.
- R10: `bus_rdata` takes the value read in the clock after the cycle in which `bus_rd` is high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NUM_SRC | Level device interrupt lines |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Number of the CPU issuing the access |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPU | Interrupt output per CPU |

## Verification
Each result falls due on a fixed cycle. A register write takes effect at the edge that samples it, and the interrupt outputs show the new state one edge after that. A change on a device line shows on the outputs at the very next edge. Read data appears at the edge after the read strobe. The driver works out the expected value from its own model of the requirements, then queues it with the exact cycle on which it falls due. The monitor samples 1.5 ns after each rising edge and compares each queued item on its due cycle. An item that reaches its cycle late is reported, not skipped.

// File: rtl/irqm_pkg.sv
// Package irqm_pkg
// Holds the register offsets, the decoded operation codes and the command
// record that passes from the bus decoder to the state modules.
// Assumes a 12-bit byte address and 32-bit data on the register bus.
package irqm_pkg;
    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned SRC_FIELD_W = 10;

    localparam logic [ADDR_W-1:0] OFS_CTRL       = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SWTRIG     = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_GEN_SET    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_GEN_CLR    = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_SWACK      = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_ROUTE_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_MASK_SET   = 12'h800;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR   = 12'h804;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CTRL,
        OP_SWTRIG,
        OP_SWACK,
        OP_GEN_SET,
        OP_GEN_CLR,
        OP_MASK_SET,
        OP_MASK_CLR,
        OP_ROUTE
    } op_e;

    typedef struct packed {
        logic                   wr;
        op_e                    op;
        logic [SRC_FIELD_W-1:0] src;
        logic                   in_range;
        logic [DATA_W-1:0]      data;
    } cmd_t;
endpackage

// File: rtl/irqm_decode.sv
// Module irqm_decode
// Turns one bus access into a command record. It names the operation and
// works out the source index. For routing registers the index comes from
// the address; for every other command it comes from the low write-data
// bits. It also flags whether that index names an existing source.
// Assumes at most one access per cycle. The record is filled for reads too,
// so that the read multiplexer can share the same decode.
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output cmd_t              cmd
);
    localparam logic [ADDR_W-1:0] ROUTE_END = ADDR_W'(OFS_ROUTE_BASE + 4 * NUM_SRC);
    localparam logic [ADDR_W-1:0] ROUTE_WIN = 12'h400;

    logic [ADDR_W-1:0]      route_off;
    logic                   route_win;
    logic [SRC_FIELD_W-1:0] route_idx;

    // Offset and index inside the routing window
    always_comb begin
        route_off = bus_addr - OFS_ROUTE_BASE;
        route_win = (bus_addr >= OFS_ROUTE_BASE) && (bus_addr < ROUTE_WIN)
                    && (bus_addr[1:0] == 2'b00);
        route_idx = SRC_FIELD_W'(route_off >> 2);
    end

    // Operation and source selection
    always_comb begin
        cmd.wr       = bus_wr;
        cmd.data     = bus_wdata;
        cmd.src      = bus_wdata[SRC_FIELD_W-1:0];
        cmd.op       = OP_NONE;
        unique case (bus_addr)
            OFS_CTRL:     cmd.op = OP_CTRL;
            OFS_SWTRIG:   cmd.op = OP_SWTRIG;
            OFS_SWACK:    cmd.op = OP_SWACK;
            OFS_GEN_SET:  cmd.op = OP_GEN_SET;
            OFS_GEN_CLR:  cmd.op = OP_GEN_CLR;
            OFS_MASK_SET: cmd.op = OP_MASK_SET;
            OFS_MASK_CLR: cmd.op = OP_MASK_CLR;
            default: begin
                if (route_win) begin
                    cmd.op  = OP_ROUTE;
                    cmd.src = route_idx;
                end
            end
        endcase
        if (cmd.op == OP_ROUTE) begin
            cmd.in_range = (bus_addr < ROUTE_END);
        end else begin
            cmd.in_range = (cmd.src < SRC_FIELD_W'(NUM_SRC));
        end
    end

    // R9: a routing index that the range check passes always names a real source
    always_comb begin
        if (cmd.op == OP_ROUTE && cmd.in_range) begin
            a_route_idx_r9: assert (route_idx < SRC_FIELD_W'(NUM_SRC));
        end
    end
endmodule

// File: rtl/irqm_global.sv
// Module irqm_global
// Holds the state shared by all CPUs: the run bit, the per-source shared
// enable and the software-pending bits. It offers the combined pending
// vector, which is the device lines ORed with the software-pending bits.
// Assumes that the command record comes from irqm_decode and that the
// device lines are already synchronous to clk.
module irqm_global
    import irqm_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_t               cmd,
    input  logic [NUM_SRC-1:0] src_irq,
    output logic               run_q,
    output logic [NUM_SRC-1:0] gen_q,
    output logic [NUM_SRC-1:0] pend
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] swp_q;
    logic [IDX_W-1:0]   idx;
    logic               act;

    assign idx  = cmd.src[IDX_W-1:0];
    assign act  = cmd.wr && cmd.in_range;
    assign pend = src_irq | swp_q;

    // Controller-wide run bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (cmd.wr && cmd.op == OP_CTRL) begin
            run_q <= cmd.data[0];
        end
    end

    // Shared enable per source, one bit per command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else if (act && cmd.op == OP_GEN_SET) begin
            gen_q[idx] <= 1'b1;
        end else if (act && cmd.op == OP_GEN_CLR) begin
            gen_q[idx] <= 1'b0;
        end
    end

    // Software pending: raised by trigger, withdrawn by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swp_q <= '0;
        end else if (act && cmd.op == OP_SWTRIG) begin
            swp_q[idx] <= 1'b1;
        end else if (act && cmd.op == OP_SWACK) begin
            swp_q[idx] <= 1'b0;
        end
    end

    // R3: a clear-enable command leaves the named source disabled
    p_gen_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cmd.op == OP_GEN_CLR) |=> !gen_q[$past(idx)]);

    // R9: an out-of-range enable command changes no enable bit
    p_gen_oob_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.wr && !cmd.in_range && (cmd.op == OP_GEN_SET || cmd.op == OP_GEN_CLR))
        |=> $stable(gen_q));

    // R7: an acknowledge withdraws the software-pending bit
    p_swack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cmd.op == OP_SWACK) |=> !swp_q[$past(idx)]);
endmodule

// File: rtl/irqm_cpu_bank.sv
// Module irqm_cpu_bank
// Holds the per-source unmask bits of one CPU and drives that CPU's
// registered interrupt output. Alias-window commands apply only when the
// issuing CPU matches CPU_ID. A routing write applies whoever issues it,
// taking write-data bit CPU_ID as the new unmask bit.
// Assumes the shared stage gives the run bit, enables and pending vector.
module irqm_cpu_bank
    import irqm_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned CPU_W   = 1,
    parameter int unsigned CPU_ID  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_t               cmd,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic               run_q,
    input  logic [NUM_SRC-1:0] gen_q,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] unm_q,
    output logic               irq_q
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [IDX_W-1:0] idx;
    logic             own;
    logic             act;
    logic             alias_op;

    assign idx      = cmd.src[IDX_W-1:0];
    assign own      = (bus_cpu == CPU_W'(CPU_ID));
    assign act      = cmd.wr && cmd.in_range;
    assign alias_op = (cmd.op == OP_MASK_SET) || (cmd.op == OP_MASK_CLR);

    // Unmask bits: alias commands for this CPU or routing writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unm_q <= '0;
        end else if (act) begin
            unique case (cmd.op)
                OP_MASK_SET: if (own) unm_q[idx] <= 1'b0;
                OP_MASK_CLR: if (own) unm_q[idx] <= 1'b1;
                OP_ROUTE:    unm_q[idx] <= cmd.data[CPU_ID];
                default:     ;
            endcase
        end
    end

    // Registered interrupt request toward this CPU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= run_q && |(pend & gen_q & unm_q);
        end
    end

    // R5: an alias write from another CPU leaves this bank untouched
    p_alias_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.wr && alias_op && !own) |=> $stable(unm_q));

    // R4: a set-mask command from this CPU masks the named source
    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act && own && cmd.op == OP_MASK_SET) |=> !unm_q[$past(idx)]);

    // R1: no request is raised while the run bit is off
    p_irq_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(run_q));
endmodule

// File: rtl/irq_dual_mask_ctrl.sv
// Module irq_dual_mask_ctrl
// Top level. It decodes bus accesses and keeps the shared enable stage. It
// builds one mask bank per CPU and returns registered read data: the run
// bit, the routing bits of a source, or zero for command registers.
// Assumes a single-cycle bus and bus_cpu below NUM_CPU. The routing
// read-back fits NUM_CPU bits into the data word.
module irq_dual_mask_ctrl
    import irqm_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_CPU = 2,
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [CPU_W-1:0]   bus_cpu,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    cmd_t                            cmd;
    logic                            run_q;
    logic [NUM_SRC-1:0]              gen_q;
    logic [NUM_SRC-1:0]              pend;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] unm_all;
    logic [NUM_CPU-1:0]              route_bits;
    logic [DATA_W-1:0]               rd_mux;

    irqm_decode #(.NUM_SRC(NUM_SRC)) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd)
    );

    irqm_global #(.NUM_SRC(NUM_SRC)) u_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .src_irq (src_irq),
        .run_q   (run_q),
        .gen_q   (gen_q),
        .pend    (pend)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        irqm_cpu_bank #(
            .NUM_SRC (NUM_SRC),
            .CPU_W   (CPU_W),
            .CPU_ID  (c)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .bus_cpu (bus_cpu),
            .run_q   (run_q),
            .gen_q   (gen_q),
            .pend    (pend),
            .unm_q   (unm_all[c]),
            .irq_q   (cpu_irq[c])
        );
        assign route_bits[c] = unm_all[c][cmd.src[IDX_W-1:0]];
    end

    // Read multiplexer over the decoded operation
    always_comb begin
        rd_mux = '0;
        unique case (cmd.op)
            OP_CTRL:  rd_mux[0] = run_q;
            OP_ROUTE: if (cmd.in_range) rd_mux[NUM_CPU-1:0] = route_bits;
            default:  ;
        endcase
    end

    // Read data register, loaded on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R8: command registers read as zero
    p_cmd_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (cmd.op == OP_SWTRIG || cmd.op == OP_SWACK || cmd.op == OP_GEN_SET
                    || cmd.op == OP_GEN_CLR || cmd.op == OP_MASK_SET
                    || cmd.op == OP_MASK_CLR)) |=> (bus_rdata == '0));

    // R10: read data only moves after a read strobe
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_dual_mask_ctrl_tb_top.sv
`timescale 1ns/100ps
module irq_dual_mask_ctrl_tb_top;
    localparam int NSRC = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_irq = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [0:0]  bus_cpu = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cpu_irq;

    irq_dual_mask_ctrl #(.NUM_SRC(NSRC), .NUM_CPU(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_cpu   (bus_cpu),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    int vecs = 0;
    int fails = 0;
    bit done = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t q[$];

    // Reference model, built from the requirements
    bit          run_m = 1'b0;
    logic [31:0] gen_m = '0, swp_m = '0, u0_m = '0, u1_m = '0;

    function automatic logic [31:0] exp_irq();
        logic [31:0] p;
        p = src_irq | swp_m;
        return {30'b0, run_m && |(p & gen_m & u1_m), run_m && |(p & gen_m & u0_m)};
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int i;
        if (a == 12'h000) return {31'b0, run_m};
        if (a >= 12'h100 && a < 12'h180 && a[1:0] == 2'b00) begin
            i = (a - 12'h100) >> 2;
            return {30'b0, u1_m[i], u0_m[i]};
        end
        return '0;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d, input int cpu);
        int n;
        n = d[9:0];
        if (a == 12'h000) run_m = d[0];
        else if (a >= 12'h100 && a < 12'h180 && a[1:0] == 2'b00) begin
            n = (a - 12'h100) >> 2;
            u0_m[n] = d[0];
            u1_m[n] = d[1];
        end else if (n < NSRC) begin
            case (a)
                12'h004: swp_m[n] = 1'b1;
                12'h010: swp_m[n] = 1'b0;
                12'h008: gen_m[n] = 1'b1;
                12'h00C: gen_m[n] = 1'b0;
                12'h800: if (cpu == 0) u0_m[n] = 1'b0; else u1_m[n] = 1'b0;
                12'h804: if (cpu == 0) u0_m[n] = 1'b1; else u1_m[n] = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic push(input bit r, input logic [31:0] v, input int due, input string tag);
        exp_t e;
        e.due = due; e.is_rd = r; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    // Driver tasks: called at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input int cpu, input string tag);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = 1'(cpu);
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d, cpu);
        push(1'b0, exp_irq(), cyc + 1, tag);
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input int cpu, input string tag);
        bus_rd = 1'b1; bus_addr = a; bus_cpu = 1'(cpu);
        push(1'b1, exp_read(a), cyc + 1, tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v, input string tag);
        src_irq = v;
        push(1'b0, exp_irq(), cyc + 1, tag);
        @(negedge clk);
    endtask

    // Monitor: compares queued items on their due cycle
    always @(posedge clk) begin
        #1.5;
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            logic [31:0] act;
            e = q.pop_front();
            vecs++;
            act = e.is_rd ? bus_rdata : {30'b0, cpu_irq};
            if (e.due != cyc || act !== e.val) begin
                fails++;
                $display("FAIL %s: %s got %h expected %h (due %0d, seen %0d)",
                         e.tag, e.is_rd ? "rdata" : "cpu_irq", act, e.val, e.due, cyc);
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog (all requirements): got hang expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        set_src('0, "R2 outputs after reset");
        rd(12'h000, 0, "R2 run bit after reset");
        rd(12'h114, 0, "R2 routing bits after reset");
        // R8 control register
        wr(12'h000, 32'h1, 0, "R8 run on");
        rd(12'h000, 1, "R8 R10 control readback");
        // R1 gating order: pending, enabled, unmasked
        set_src(32'h8, "R1 pending but disabled");
        wr(12'h008, 32'd3, 0, "R3 enable, still masked");
        wr(12'h804, 32'd3, 0, "R4 unmask cpu0");
        rd(12'h10C, 1, "R6 routing shows cpu0 alias unmask");
        wr(12'h804, 32'd3, 1, "R4 unmask cpu1");
        wr(12'h800, 32'd3, 1, "R5 mask cpu1, cpu0 kept");
        wr(12'h00C, 32'd3, 0, "R3 clear enable");
        wr(12'h008, 32'd3, 1, "R3 set enable again");
        // R6 routing register
        wr(12'h11C, 32'h2, 0, "R6 route source 7 to cpu1");
        rd(12'h11C, 0, "R6 routing readback");
        wr(12'h008, 32'd7, 0, "R3 enable source 7");
        // R7 software trigger and acknowledge
        wr(12'h004, 32'd7, 1, "R7 software trigger");
        set_src('0, "R7 device line dropped, sw pending kept");
        wr(12'h010, 32'd7, 0, "R7 acknowledge");
        set_src(32'h80, "R7 device line alone");
        set_src(32'h8, "R1 swap pending source");
        // R9 out-of-range numbers
        wr(12'h00C, 32'd35, 0, "R9 clear enable 35 ignored");
        wr(12'h800, 32'd35, 0, "R9 set mask 35 ignored");
        wr(12'h004, 32'd39, 0, "R9 trigger 39 ignored");
        rd(12'h10C, 0, "R9 routing of 3 unchanged");
        wr(12'h180, 32'h3, 0, "R9 routing write beyond 31");
        rd(12'h100, 0, "R9 routing of 0 unchanged");
        rd(12'h180, 0, "R9 routing beyond 31 reads zero");
        // R8 command registers read zero
        rd(12'h004, 0, "R8 trigger reads zero");
        rd(12'h008, 0, "R8 set-enable reads zero");
        rd(12'h00C, 0, "R8 clear-enable reads zero");
        rd(12'h010, 1, "R8 acknowledge reads zero");
        rd(12'h800, 0, "R8 set-mask reads zero");
        rd(12'h804, 1, "R8 clear-mask reads zero");
        // R1 run bit
        wr(12'h000, 32'h0, 0, "R1 run off");
        wr(12'h000, 32'h1, 0, "R1 run on");
        // R1 top source
        wr(12'h008, 32'd31, 0, "R3 enable source 31");
        wr(12'h17C, 32'h3, 1, "R6 route 31 to both");
        set_src(32'h8000_0000, "R1 source 31 to both CPUs");
        rd(12'h17C, 0, "R6 routing of 31");
        set_src('0, "R1 all quiet");
        repeat (4) @(negedge clk);
        summary();
    end
endmodule